// File: doc/BRIEF.md
# Load-Store Unit with Console Window

This block sits between the execute stage of a 32-bit core and a byte-addressed data RAM. Each request carries a base register value, the immediate and destination fields of the instruction word, a three-bit function code, store data and one load or store strobe. The block adds the sign-extended 12-bit immediate to the base to form the effective address. It then either drives the RAM port, with a lane-aligned word address, byte enables and lane-shifted write data, or produces the load result one cycle later.

Address bit 31 splits the space into two halves. The lower half is RAM. In the upper half, the single address 0x80000000 is a write-only console: a store there sends its truncated data to the console output and never reaches RAM. Stores to any other upper-half address are dropped without any error. Every load from the upper half returns zero and makes no RAM access.

A small state machine sequences the work. It has three states:
- `ST_IDLE` accepts requests.
- `ST_RAM_RSP` is the cycle in which RAM read data is valid.
- `ST_ZERO_RSP` answers an upper-half load with zero.

It has three transitions:
- The idle-to-RAM-response transition is taken by a load whose address is in the lower half.
- The idle-to-zero-response transition is taken by a load whose address is in the upper half.
- Both response states always return to idle after one cycle.

Stores complete within the idle cycle in which they arrive.

Top module: `lsu_console_top`

## Requirements
- R1: The effective address is `base_addr` plus the sign-extended 12-bit immediate. For a load the immediate is `{imm_hi, imm_mid}`, taken from instruction bits 31:20. For a store it is `{imm_hi, rd_field}`, taken from instruction bits 31:25 and 11:7.
- R2: `fn_code[1:0]` selects the access size: 0 is a byte, 1 is a halfword and 2 is a word. Code 3 behaves as a word.
- R3: A store whose address has bit 31 clear raises `ram_en` and `ram_we` in the same cycle as the strobe. `ram_addr` is the effective address with bits 1:0 cleared. `ram_be` holds the size mask (byte 0001, half 0011, word 1111) shifted left by address bits 1:0. `ram_wdata` holds `store_data` shifted left by 8 times address bits 1:0, in little-endian order.
- R4: A load whose address has bit 31 clear raises `ram_en` with `ram_we` low in the strobe cycle. `ram_rdata` is taken in the following cycle, in which `ld_valid` is high and `ld_data` holds the addressed lane shifted down to bit 0.
- R5: Byte and halfword loads are sign-extended when `fn_code[2]` is 0 and zero-extended when it is 1.
- R6: A store to exactly 0x80000000 raises `con_valid` in the strobe cycle. `con_data` holds `store_data` truncated to the access size, in the low lanes. `con_be` marks those lanes. `ram_en` stays low.
- R7: A store to any other address with bit 31 set drives neither RAM nor the console.
- R8: A load from an address with bit 31 set makes no RAM access. It returns `ld_data` of 0 with `ld_valid` high in the next cycle.
- R9: A load whose destination index `rd_field` is 0 never raises `ld_valid`.
- R10: When both strobes are high in one idle cycle, the load is performed and the store is dropped.
- R11: A strobe arriving in a response cycle, the cycle after an accepted load, is ignored.
- R12: After reset `ld_valid`, `ram_en`, `ram_we` and `con_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_load | input | 1 | Load strobe |
| req_store | input | 1 | Store strobe |
| base_addr | input | 32 | Base register value |
| imm_hi | input | 7 | Instruction bits 31:25 |
| imm_mid | input | 5 | Instruction bits 24:20 |
| rd_field | input | 5 | Instruction bits 11:7 (load destination or store immediate low part) |
| fn_code | input | 3 | Function bits: size in 1:0, zero-extend in 2 |
| store_data | input | 32 | Store source register value |
| ld_valid | output | 1 | Load result valid |
| ld_rd | output | 5 | Destination index of the result |
| ld_data | output | 32 | Extended load result |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 32 | Word-aligned RAM address |
| ram_be | output | 4 | RAM byte enables |
| ram_wdata | output | 32 | Lane-steered RAM write data |
| ram_rdata | input | 32 | RAM read data, valid one cycle after a read |
| con_valid | output | 1 | Console write strobe |
| con_be | output | 4 | Console valid lanes |
| con_data | output | 32 | Console data, truncated to the access size |

## Verification
The bench targets the lane arithmetic at every offset and size. A wrong shift shows up as a byte written into the neighbouring lane, or as a load that returns the wrong byte. Negative bytes and halfwords read back through both the signed and unsigned variants expose a missing or inverted extension. The bench also drives stores with negative split immediates, where using the load-format immediate would hit a different word. Further cases are stores one word past the console address and loads anywhere in the upper half, which catch a design that decodes only bit 31 or leaks upper-half accesses onto the RAM port. The remaining cases are collisions: both strobes together, and a store arriving in the response cycle. A design that mishandles either corrupts RAM, and a later load reveals the corruption.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RAM_RSP  = 2'd1,
        ST_ZERO_RSP = 2'd2
    } lsu_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [1:0] off;
        acc_size_e  size;
        logic       zext;
        logic [4:0] rd;
    } pend_load_t;

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
    parameter int          XLEN         = 32,
    parameter int          IMMW         = 12,
    parameter logic [31:0] CONSOLE_ADDR = 32'h8000_0000
) (
    input  logic [XLEN-1:0] base,
    input  logic [6:0]      imm_hi,
    input  logic [4:0]      imm_mid,
    input  logic [4:0]      imm_st_lo,
    input  logic            store_form,
    output logic [XLEN-1:0] ea,
    output logic            in_ram,
    output logic            is_console
);
    logic [IMMW-1:0] imm;
    logic [XLEN-1:0] imm_ext;

    always_comb begin
        imm     = store_form ? {imm_hi, imm_st_lo} : {imm_hi, imm_mid};
        imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        ea      = base + imm_ext;
        in_ram     = ~ea[XLEN-1];
        is_console = (ea == CONSOLE_ADDR[XLEN-1:0]);
    end
endmodule

// File: rtl/lsu_wr_steer.sv
module lsu_wr_steer
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NLANE = XLEN / 8,
    localparam int OFFW  = $clog2(NLANE)
) (
    input  acc_size_e        size,
    input  logic [OFFW-1:0]  off,
    input  logic [XLEN-1:0]  data,
    output logic [NLANE-1:0] be,
    output logic [XLEN-1:0]  wdata,
    output logic [NLANE-1:0] con_be,
    output logic [XLEN-1:0]  con_data
);
    logic [OFFW:0]      nbytes;
    logic [NLANE-1:0]   lane_mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = (OFFW+1)'(1);
            SZ_HALF: nbytes = (OFFW+1)'(2);
            default: nbytes = (OFFW+1)'(NLANE);
        endcase
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign lane_mask[i]        = ((OFFW+1)'(i) < nbytes);
        assign con_data[i*8 +: 8]  = lane_mask[i] ? data[i*8 +: 8] : 8'h00;
    end

    assign con_be = lane_mask;
    assign be     = lane_mask << off;
    assign wdata  = data << {off, 3'b000};
endmodule

// File: rtl/lsu_rd_align.sv
module lsu_rd_align
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NLANE = XLEN / 8,
    localparam int OFFW  = $clog2(NLANE)
) (
    input  logic [XLEN-1:0] rdata,
    input  logic [OFFW-1:0] off,
    input  acc_size_e       size,
    input  logic            zext,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] shifted;

    always_comb begin
        shifted = rdata >> {off, 3'b000};
        unique case (size)
            SZ_BYTE: result = {{(XLEN-8){~zext & shifted[7]}}, shifted[7:0]};
            SZ_HALF: result = {{(XLEN-16){~zext & shifted[15]}}, shifted[15:0]};
            default: result = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_console_top.sv
module lsu_console_top
    import lsu_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter logic [31:0] CONSOLE_ADDR = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_load,
    input  logic              req_store,
    input  logic [XLEN-1:0]   base_addr,
    input  logic [6:0]        imm_hi,
    input  logic [4:0]        imm_mid,
    input  logic [4:0]        rd_field,
    input  logic [2:0]        fn_code,
    input  logic [XLEN-1:0]   store_data,
    output logic              ld_valid,
    output logic [4:0]        ld_rd,
    output logic [XLEN-1:0]   ld_data,
    output logic              ram_en,
    output logic              ram_we,
    output logic [XLEN-1:0]   ram_addr,
    output logic [XLEN/8-1:0] ram_be,
    output logic [XLEN-1:0]   ram_wdata,
    input  logic [XLEN-1:0]   ram_rdata,
    output logic              con_valid,
    output logic [XLEN/8-1:0] con_be,
    output logic [XLEN-1:0]   con_data
);
    localparam int NLANE = XLEN / 8;
    localparam int OFFW  = $clog2(NLANE);

    lsu_state_e       state, state_nx;
    pend_load_t       pend;
    logic             st_req;
    logic [XLEN-1:0]  ea;
    logic             in_ram, is_console;
    acc_size_e        req_size;
    logic [NLANE-1:0] st_be, c_be;
    logic [XLEN-1:0]  st_wdata, c_data, aligned;
    logic             hi_pending;

    // A simultaneous load wins (R10)
    assign st_req   = req_store & ~req_load;
    assign req_size = acc_size_e'(fn_code[1:0]);

    lsu_ea_gen #(.XLEN(XLEN), .CONSOLE_ADDR(CONSOLE_ADDR)) u_ea (
        .base(base_addr), .imm_hi(imm_hi), .imm_mid(imm_mid), .imm_st_lo(rd_field),
        .store_form(st_req), .ea(ea), .in_ram(in_ram), .is_console(is_console)
    );

    lsu_wr_steer #(.XLEN(XLEN)) u_wr (
        .size(req_size), .off(ea[OFFW-1:0]), .data(store_data),
        .be(st_be), .wdata(st_wdata), .con_be(c_be), .con_data(c_data)
    );

    lsu_rd_align #(.XLEN(XLEN)) u_rd (
        .rdata(ram_rdata), .off(pend.off), .size(pend.size), .zext(pend.zext),
        .result(aligned)
    );

    // State register and pending-load capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pend       <= '0;
            hi_pending <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_load) begin
                pend.off   <= ea[1:0];
                pend.size  <= req_size;
                pend.zext  <= fn_code[2];
                pend.rd    <= rd_field;
                hi_pending <= ~in_ram;
            end
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_load) state_nx = in_ram ? ST_RAM_RSP : ST_ZERO_RSP;
            end
            ST_RAM_RSP:  state_nx = ST_IDLE;
            ST_ZERO_RSP: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = {ea[XLEN-1:2], 2'b00};
        ram_be    = '0;
        ram_wdata = '0;
        con_valid = 1'b0;
        con_be    = '0;
        con_data  = '0;
        ld_valid  = 1'b0;
        ld_rd     = pend.rd;
        ld_data   = '0;
        unique case (state)
            ST_IDLE: begin
                ram_en = (req_load | st_req) & in_ram;
                ram_we = st_req & in_ram;
                if (st_req & in_ram) begin
                    ram_be    = st_be;
                    ram_wdata = st_wdata;
                end
                if (st_req & is_console) begin
                    con_valid = 1'b1;
                    con_be    = c_be;
                    con_data  = c_data;
                end
            end
            ST_RAM_RSP: begin
                ld_valid = (pend.rd != 5'd0);
                ld_data  = aligned;
            end
            ST_ZERO_RSP: begin
                ld_valid = (pend.rd != 5'd0);
            end
            default: ;
        endcase
    end

    // Assertions
    assert_ram_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> !ram_addr[XLEN-1]);

    assert_console_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid |-> !ram_en);

    assert_load_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_load && rd_field != 5'd0) |=> ld_valid);

    assert_rd_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ld_rd != 5'd0);

    assert_resp_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (!ram_en && !con_valid));

    assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && fn_code[1:0] == 2'd0) |-> $onehot(ram_be));

    assert_high_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hi_pending) |-> ld_data == '0);

endmodule

// File: tb/sim_lsu_console_top.sv
`timescale 1ns/1ps
module sim_lsu_console_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_load, req_store;
    logic [31:0] base_addr, store_data, ld_data, ram_addr, ram_wdata, con_data;
    logic [31:0] ram_rdata;
    logic [6:0]  imm_hi;
    logic [4:0]  imm_mid, rd_field, ld_rd;
    logic [2:0]  fn_code;
    logic        ld_valid, ram_en, ram_we, con_valid;
    logic [3:0]  ram_be, con_be;

    logic [31:0] mem     [0:255];
    logic [31:0] ref_mem [0:255];
    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lsu_console_top u0 (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_store(req_store),
        .base_addr(base_addr), .imm_hi(imm_hi), .imm_mid(imm_mid), .rd_field(rd_field),
        .fn_code(fn_code), .store_data(store_data), .ld_valid(ld_valid), .ld_rd(ld_rd),
        .ld_data(ld_data), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_be(ram_be), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .con_valid(con_valid), .con_be(con_be), .con_data(con_data)
    );

    function automatic logic [31:0] init_word(int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // RAM model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
            ram_rdata <= '0;
        end else if (ram_en) begin
            if (ram_we) begin
                for (int b = 0; b < 4; b++)
                    if (ram_be[b]) mem[ram_addr[9:2]][b*8 +: 8] <= ram_wdata[b*8 +: 8];
            end else begin
                ram_rdata <= mem[ram_addr[9:2]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx12(logic [11:0] v);
        return {{20{v[11]}}, v};
    endfunction

    function automatic logic [3:0] exp_be(logic [31:0] ea, logic [2:0] f);
        logic [3:0] m;
        m = (f[1:0] == 2'd0) ? 4'b0001 : (f[1:0] == 2'd1) ? 4'b0011 : 4'b1111;
        return 4'(m << ea[1:0]);
    endfunction

    function automatic logic [31:0] exp_load(logic [31:0] ea, logic [2:0] f);
        logic [31:0] s;
        s = ref_mem[ea[9:2]] >> (8 * ea[1:0]);
        case (f[1:0])
            2'd0: return f[2] ? {24'h0, s[7:0]} : {{24{s[7]}}, s[7:0]};
            2'd1: return f[2] ? {16'h0, s[15:0]} : {{16{s[15]}}, s[15:0]};
            default: return s;
        endcase
    endfunction

    function automatic logic [31:0] lane_trunc(logic [31:0] d, logic [2:0] f);
        return (f[1:0] == 2'd0) ? {24'h0, d[7:0]} : (f[1:0] == 2'd1) ? {16'h0, d[15:0]} : d;
    endfunction

    task automatic idle_inputs();
        req_load = 0; req_store = 0;
    endtask

    task automatic do_store(input logic [31:0] base, input logic [11:0] imm,
                            input logic [31:0] data, input logic [2:0] f);
        logic [31:0] ea;
        logic [3:0]  be;
        @(negedge clk);
        base_addr = base; imm_hi = imm[11:5]; rd_field = imm[4:0]; imm_mid = 5'h1F;
        fn_code = f; store_data = data; req_store = 1;
        #1;
        ea = base + sx12(imm);
        if (!ea[31]) begin
            be = exp_be(ea, f);
            chk(ram_en && ram_we, "R3 write enable", {30'h0, ram_en, ram_we}, 32'h3);
            chk(ram_addr == {ea[31:2], 2'b00}, "R1 store address", ram_addr, {ea[31:2], 2'b00});
            chk(ram_be == be, "R3 byte enables", {28'h0, ram_be}, {28'h0, be});
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_mem[ea[9:2]][b*8 +: 8] = 8'(data >> (8 * (b - ea[1:0])));
        end else if (ea == 32'h8000_0000) begin
            chk(con_valid && !ram_en, "R6 console strobe", {30'h0, con_valid, ram_en}, 32'h2);
            chk(con_data == lane_trunc(data, f), "R6 console data", con_data, lane_trunc(data, f));
            chk(con_be == exp_be(32'h0, f), "R6 console lanes", {28'h0, con_be}, {28'h0, exp_be(32'h0, f)});
        end else begin
            chk(!ram_en && !con_valid, "R7 high store dropped", {30'h0, ram_en, con_valid}, 32'h0);
        end
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic do_load(input logic [31:0] base, input logic [11:0] imm,
                           input logic [2:0] f, input logic [4:0] rd, input string req);
        logic [31:0] ea, exp;
        @(negedge clk);
        base_addr = base; imm_hi = imm[11:5]; imm_mid = imm[4:0]; rd_field = rd;
        fn_code = f; req_load = 1; store_data = 32'hDEAD_BEEF;
        #1;
        ea = base + sx12(imm);
        chk(ram_en == !ea[31] && !ram_we, "R4/R8 read request", {30'h0, ram_en, ram_we}, {31'h0, !ea[31]});
        @(posedge clk); #1;
        idle_inputs();
        @(negedge clk);
        exp = ea[31] ? 32'h0 : exp_load(ea, f);
        if (rd == 5'd0) begin
            chk(!ld_valid, "R9 discarded load", {31'h0, ld_valid}, 32'h0);
        end else begin
            chk(ld_valid && ld_rd == rd, {req, " valid/rd"}, {26'h0, ld_valid, ld_rd}, {26'h0, 1'b1, rd});
            chk(ld_data == exp, req, ld_data, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) ref_mem[i] = init_word(i);
        rst_n = 0; idle_inputs();
        base_addr = '0; imm_hi = '0; imm_mid = '0; rd_field = '0; fn_code = '0; store_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!ld_valid && !ram_en && !ram_we && !con_valid, "R12 reset outputs",
            {28'h0, ld_valid, ram_en, ram_we, con_valid}, 32'h0);

        // Directed: sign and zero extension (R5), lane offsets (R3)
        do_store(32'h100, 12'h003, 32'h0000_0080, 3'd0);
        do_load (32'h100, 12'h003, 3'd0, 5'd3, "R5 signed byte");
        do_load (32'h100, 12'h003, 3'd4, 5'd3, "R5 unsigned byte");
        do_store(32'h200, 12'h002, 32'h1234_9ABC, 3'd1);
        do_load (32'h200, 12'h002, 3'd1, 5'd4, "R5 signed half");
        do_load (32'h200, 12'h002, 3'd5, 5'd4, "R5 unsigned half");
        // Negative split immediate for store and load (R1)
        do_store(32'h140, 12'hFFC, 32'hCAFE_F00D, 3'd2);
        do_load (32'h13C, 12'h000, 3'd2, 5'd7, "R1 store imm split");
        do_load (32'h144, 12'hFF8, 3'd2, 5'd7, "R1 load imm negative");
        // Console window (R6) and dropped high stores (R7)
        do_store(32'h8000_0000, 12'h000, 32'h4142_4344, 3'd2);
        do_store(32'h8000_0010, 12'hFF0, 32'h0000_0A55, 3'd0);
        do_store(32'h7FFF_FFF0, 12'h010, 32'h0000_7766, 3'd1);
        do_store(32'h8000_0004, 12'h000, 32'h1111_1111, 3'd2);
        do_store(32'hFFFF_FFF0, 12'h000, 32'h2222_2222, 3'd0);
        do_load (32'h0, 12'h000, 3'd2, 5'd1, "R7 RAM unchanged");
        // High-half loads (R8)
        do_load (32'h8000_0000, 12'h000, 3'd2, 5'd5, "R8 console load zero");
        do_load (32'h9000_0100, 12'h7FF, 3'd0, 5'd5, "R8 high load zero");
        // Destination zero (R9)
        do_load (32'h100, 12'h000, 3'd2, 5'd0, "R9");

        // Both strobes (R10)
        @(negedge clk);
        base_addr = 32'h180; imm_hi = 0; imm_mid = 0; rd_field = 5'd9; fn_code = 3'd2;
        store_data = 32'h5555_AAAA; req_load = 1; req_store = 1;
        #1 chk(ram_en && !ram_we, "R10 load wins", {30'h0, ram_en, ram_we}, 32'h2);
        @(posedge clk); #1 idle_inputs();
        @(negedge clk);
        chk(ld_valid && ld_data == ref_mem[8'h60], "R10 load data", ld_data, ref_mem[8'h60]);

        // Store during response cycle is ignored (R11)
        @(negedge clk);
        base_addr = 32'h1C0; imm_hi = 0; imm_mid = 0; rd_field = 5'd2; fn_code = 3'd2; req_load = 1;
        @(posedge clk); #1;
        req_load = 0; req_store = 1; base_addr = 32'h1C4; rd_field = 5'd0; store_data = 32'h0BAD_0BAD;
        @(negedge clk);
        chk(!ram_we && !con_valid, "R11 response-cycle store", {30'h0, ram_we, con_valid}, 32'h0);
        @(posedge clk); #1 idle_inputs();
        do_load(32'h1C4, 12'h000, 3'd2, 5'd6, "R11 RAM unchanged");

        // Random mix (R2, R3, R4, R5)
        for (int n = 0; n < 300; n++) begin
            logic [2:0]  f;
            logic [31:0] base, d;
            logic [11:0] imm;
            int al;
            f = 3'($urandom_range(0, 2));
            if ($urandom_range(0, 1) == 1 && f != 3'd2) f[2] = 1'b1;
            al = (f[1:0] == 2'd0) ? 1 : (f[1:0] == 2'd1) ? 2 : 4;
            base = 32'($urandom_range(64, 900)) & ~32'(al - 1);
            imm  = 12'($signed($urandom_range(0, 127)) - 64) & ~12'(al - 1);
            d = $urandom;
            if ($urandom_range(0, 1) == 1) do_store(base, imm, d, {1'b0, f[1:0]});
            else do_load(base, imm, f, 5'($urandom_range(1, 31)), "R2/R5 random load");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule